// File: doc/BRIEF.md
# Interlocked Request/Acknowledge Bus Transfer Link

This block carries single-word reads and writes between a requesting side and a responding side that run on unrelated clocks. There is no shared bus timing. Each transfer is paced by two active-low strobes: a request strobe owned by the initiator and an acknowledge strobe owned by the responder. The initiator drives an 18-bit address and a 2-bit transfer code, and on a write also the 16-bit data word. After a programmable settle delay it lowers the request strobe. The responder lowers the acknowledge strobe once its storage has finished the access. The initiator then raises its strobe, and the responder raises its own and frees the data lines. Each end sees the other end's strobe only through a synchronizer clocked in its own domain.

A small word memory with a per-transfer latency input sits behind the responder. The latency may be anything from zero upwards, and the transfer still completes correctly. The initiator carries a programmable watchdog. If no acknowledge arrives within the limit, it drops the request strobe and reports the transfer as timed out.

Top module: `hs_link`

## Requirements
- R1: After reset, `busMsynN` and `busSsynN` are high (deasserted), `reqReady` is high and `doneValid` is low.
- R2: All bus transfer lines are active low. While a transfer is in progress, `busAddrN` carries the inverted address and `busCtlN` carries the inverted code, where the code is 00 for a read and 10 for a write (so `busCtlN` reads 11 for a read and 01 for a write). `busMsynN` falls exactly `cfgSettle`+1 master clock cycles after the cycle in which the request is accepted, and the address and code stay unchanged while `busMsynN` is low.
- R3: On the bus, the acknowledge strobe falls only while the request strobe is low. The request strobe rises only after the acknowledge strobe is low, except when the watchdog fires. The acknowledge strobe rises only after the request strobe is high. A new request strobe falls only while the acknowledge strobe is high.
- R4: A read returns, on `doneData` with `doneValid`, the word last written to the selected location. The responder drives that word onto the data lines before it lowers the acknowledge strobe.
- R5: A write stores `reqData` at the selected location before the acknowledge strobe falls.
- R6: Only the low `MEM_AW` address bits select a memory word. Higher address bits are ignored, so addresses that differ only above those bits alias.
- R7: Any responder latency (`slvDelay`, counted in responder cycles) completes the transfer correctly with `doneTimeout` low, provided the acknowledge arrives within the watchdog limit.
- R8: If the acknowledge does not arrive within `cfgTimeout` master cycles after the request strobe falls, the initiator raises the request strobe and pulses `doneValid` with `doneTimeout` high.
- R9: A write abandoned by the watchdog before the responder finished its latency leaves the memory unchanged.
- R10: `reqReady` is low from the cycle after a request is accepted until the transfer has fully completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mClk | input | 1 | Initiator clock |
| mRstN | input | 1 | Initiator asynchronous reset, active low |
| sClk | input | 1 | Responder clock |
| sRstN | input | 1 | Responder asynchronous reset, active low |
| cfgSettle | input | 8 | Cycles between driving address and lowering the request strobe |
| cfgTimeout | input | 16 | Watchdog limit in initiator cycles |
| reqValid | input | 1 | Transfer request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 18 | Transfer address |
| reqData | input | 16 | Write data |
| reqReady | output | 1 | Initiator idle, accepts a request |
| doneValid | output | 1 | One-cycle completion pulse |
| doneTimeout | output | 1 | Completed transfer was abandoned by the watchdog |
| doneData | output | 16 | Read data of the completed transfer |
| slvDelay | input | 8 | Responder access latency in responder cycles |
| busMsynN | output | 1 | Request strobe on the bus, active low |
| busSsynN | output | 1 | Acknowledge strobe on the bus, active low |
| busAddrN | output | 18 | Address lines, active low |
| busCtlN | output | 2 | Transfer-code lines, active low |

## Verification
The bench keeps the default widths: 18 address bits, 16 data bits and a 64-word memory. With 64 words, aliasing through address bits above bit 5 can be reached by a single pair of transfers. The two clocks run at 10 and 14 time units so that the strobe edges drift against each other. Settle delays of 0 to 5 and responder latencies of 0 to 11 cover the early and late acknowledge cases under a watchdog limit of 60. A limit of 20 against a latency of 200 forces the timeout path for both a read and a write.

// File: rtl/hs_pkg.sv
package hs_pkg;
  // Transfer code as seen before bus inversion (C1,C0)
  typedef enum logic [1:0] {XFER_READ = 2'b00, XFER_WRITE = 2'b10} xferCode_e;

  typedef enum logic [1:0] {M_IDLE, M_SETTLE, M_WAIT, M_RELEASE} mstState_e;
  typedef enum logic [1:0] {S_IDLE, S_LAT, S_DRIVE, S_ACK} slvState_e;

  // Strobes from initiator control to initiator datapath
  typedef struct packed {
    logic load;
    logic cntClr;
    logic cntInc;
    logic msynOn;
    logic msynOff;
    logic capture;
    logic flagTimeout;
    logic finish;
  } mstStrobe_t;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : gSingle
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain <= RST_VAL;
        else       chain <= d;
    end else begin : gMulti
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain <= {STAGES{RST_VAL}};
        else       chain <= {chain[STAGES-2:0], d};
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hs_master_ctl.sv
module hs_master_ctl
  import hs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       settleHit,
  input  logic       timeoutHit,
  input  logic       ssynSeen,
  output logic       reqReady,
  output mstStrobe_t stb
);
  mstState_e state, nextState;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) state <= M_IDLE;
    else       state <= nextState;

  always_comb begin
    stb       = '0;
    nextState = state;
    case (state)
      M_IDLE: if (reqValid) begin
        stb.load   = 1'b1;
        stb.cntClr = 1'b1;
        nextState  = M_SETTLE;
      end
      M_SETTLE: if (settleHit) begin
        stb.msynOn = 1'b1;
        stb.cntClr = 1'b1;
        nextState  = M_WAIT;
      end else begin
        stb.cntInc = 1'b1;
      end
      M_WAIT: if (ssynSeen) begin
        stb.capture = 1'b1;
        stb.msynOff = 1'b1;
        nextState   = M_RELEASE;
      end else if (timeoutHit) begin
        stb.flagTimeout = 1'b1;
        stb.msynOff     = 1'b1;
        nextState       = M_RELEASE;
      end else begin
        stb.cntInc = 1'b1;
      end
      M_RELEASE: if (!ssynSeen) begin
        stb.finish = 1'b1;
        nextState  = M_IDLE;
      end
      default: nextState = M_IDLE;
    endcase
  end

  assign reqReady = (state == M_IDLE);

  AST_NO_START_ON_LIVE_ACK: assert property (@(posedge clk) disable iff (!rstN)
    stb.msynOn |-> !ssynSeen); // R3
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && reqValid) |=> !reqReady); // R10
endmodule

// File: rtl/hs_master_dp.sv
module hs_master_dp
  import hs_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter int DATA_W   = 16,
  parameter int CNT_W    = 16,
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  mstStrobe_t          stb,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqData,
  input  logic [SETTLE_W-1:0] cfgSettle,
  input  logic [CNT_W-1:0]    cfgTimeout,
  input  logic [DATA_W-1:0]   busDataN,
  output logic                settleHit,
  output logic                timeoutHit,
  output logic                msynN,
  output logic [ADDR_W-1:0]   addrN,
  output logic [1:0]          ctlN,
  output logic [DATA_W-1:0]   dataN,
  output logic                doneValid,
  output logic                doneTimeout,
  output logic [DATA_W-1:0]   doneData
);
  logic [ADDR_W-1:0] addrR;
  logic [DATA_W-1:0] dataR;
  logic [DATA_W-1:0] rdData;
  logic [CNT_W-1:0]  cnt;
  xferCode_e         codeR;
  logic              driveR, msynR, toFlag, doneR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrR  <= '0;
      dataR  <= '0;
      rdData <= '0;
      cnt    <= '0;
      codeR  <= XFER_READ;
      driveR <= 1'b0;
      msynR  <= 1'b0;
      toFlag <= 1'b0;
      doneR  <= 1'b0;
    end else begin
      doneR <= 1'b0;
      if (stb.load) begin
        addrR  <= reqAddr;
        dataR  <= reqData;
        codeR  <= reqWrite ? XFER_WRITE : XFER_READ;
        driveR <= 1'b1;
        toFlag <= 1'b0;
      end
      if (stb.cntClr)      cnt <= '0;
      else if (stb.cntInc) cnt <= cnt + 1'b1;
      if (stb.msynOn)      msynR <= 1'b1;
      if (stb.msynOff)     msynR <= 1'b0;
      if (stb.capture)     rdData <= ~busDataN;
      if (stb.flagTimeout) toFlag <= 1'b1;
      if (stb.finish) begin
        driveR <= 1'b0;
        doneR  <= 1'b1;
      end
    end
  end

  assign settleHit   = (cnt == CNT_W'(cfgSettle));
  assign timeoutHit  = (cnt == cfgTimeout);
  assign msynN       = ~msynR;
  assign addrN       = driveR ? ~addrR : '1;
  assign ctlN        = driveR ? ~codeR : 2'b11;
  assign dataN       = (driveR && codeR == XFER_WRITE) ? ~dataR : '1;
  assign doneValid   = doneR;
  assign doneTimeout = toFlag;
  assign doneData    = rdData;

  AST_ADDR_HELD_UNDER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (!msynN && $past(!msynN)) |-> ($stable(addrN) && $stable(ctlN))); // R2
  AST_REQ_HAS_LINES: assert property (@(posedge clk) disable iff (!rstN)
    !msynN |-> (ctlN != 2'b11 || codeR == XFER_READ) && driveR); // R2
endmodule

// File: rtl/hs_slave.sv
module hs_slave
  import hs_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  parameter int MEM_AW = 6,
  parameter int LAT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              msynSeen,
  input  logic [ADDR_W-1:0] busAddrN,
  input  logic [1:0]        busCtlN,
  input  logic [DATA_W-1:0] busDataN,
  input  logic [LAT_W-1:0]  slvDelay,
  output logic              ssynN,
  output logic [DATA_W-1:0] dataN
);
  localparam int DEPTH = 1 << MEM_AW;

  logic [DATA_W-1:0] mem [DEPTH];
  slvState_e         state;
  logic [LAT_W-1:0]  latCnt;
  logic [MEM_AW-1:0] idx;
  logic [DATA_W-1:0] dataOut;
  logic              isWrite, drvData, ssynR, memWe;

  assign memWe = (state == S_LAT) && msynSeen && (latCnt == '0) && isWrite;

  always_ff @(posedge clk)
    if (memWe) mem[idx] <= ~busDataN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      latCnt  <= '0;
      idx     <= '0;
      dataOut <= '0;
      isWrite <= 1'b0;
      drvData <= 1'b0;
      ssynR   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (msynSeen) begin
          idx     <= ~busAddrN[MEM_AW-1:0];
          isWrite <= (~busCtlN == XFER_WRITE);
          latCnt  <= slvDelay;
          state   <= S_LAT;
        end
        S_LAT: begin
          if (!msynSeen) begin
            state <= S_IDLE;
          end else if (latCnt == '0) begin
            if (!isWrite) begin
              dataOut <= mem[idx];
              drvData <= 1'b1;
            end
            state <= S_DRIVE;
          end else begin
            latCnt <= latCnt - 1'b1;
          end
        end
        S_DRIVE: begin
          if (msynSeen) begin
            ssynR <= 1'b1;
            state <= S_ACK;
          end else begin
            drvData <= 1'b0;
            state   <= S_IDLE;
          end
        end
        S_ACK: if (!msynSeen) begin
          ssynR   <= 1'b0;
          drvData <= 1'b0;
          state   <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign ssynN = ~ssynR;
  assign dataN = drvData ? ~dataOut : '1;

  AST_ACK_ONLY_UNDER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ssynN) |-> $past(msynSeen)); // R3
  AST_ACK_DROP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ssynN) |-> !msynSeen); // R3
  AST_READ_DATA_UNDER_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (!ssynN && !isWrite) |-> drvData); // R4
endmodule

// File: rtl/hs_link.sv
module hs_link
  import hs_pkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int DATA_W      = 16,
  parameter int MEM_AW      = 6,
  parameter int CNT_W       = 16,
  parameter int SETTLE_W    = 8,
  parameter int LAT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                mClk,
  input  logic                mRstN,
  input  logic                sClk,
  input  logic                sRstN,
  input  logic [SETTLE_W-1:0] cfgSettle,
  input  logic [CNT_W-1:0]    cfgTimeout,
  input  logic                reqValid,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqData,
  output logic                reqReady,
  output logic                doneValid,
  output logic                doneTimeout,
  output logic [DATA_W-1:0]   doneData,
  input  logic [LAT_W-1:0]    slvDelay,
  output logic                busMsynN,
  output logic                busSsynN,
  output logic [ADDR_W-1:0]   busAddrN,
  output logic [1:0]          busCtlN
);
  mstStrobe_t        stb;
  logic              settleHit, timeoutHit;
  logic              ssynSyncN, msynSyncN;
  logic [DATA_W-1:0] mDataN, sDataN, busDataN;

  // Active-low lines combine as wired-AND: any driver pulling low wins
  assign busDataN = mDataN & sDataN;

  hs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) uAckSync (
    .clk(mClk), .rstN(mRstN), .d(busSsynN), .q(ssynSyncN));
  hs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) uReqSync (
    .clk(sClk), .rstN(sRstN), .d(busMsynN), .q(msynSyncN));

  hs_master_ctl uCtl (
    .clk(mClk), .rstN(mRstN), .reqValid(reqValid), .settleHit(settleHit),
    .timeoutHit(timeoutHit), .ssynSeen(!ssynSyncN), .reqReady(reqReady), .stb(stb));

  hs_master_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .SETTLE_W(SETTLE_W)) uDp (
    .clk(mClk), .rstN(mRstN), .stb(stb), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqData(reqData), .cfgSettle(cfgSettle), .cfgTimeout(cfgTimeout),
    .busDataN(busDataN), .settleHit(settleHit), .timeoutHit(timeoutHit),
    .msynN(busMsynN), .addrN(busAddrN), .ctlN(busCtlN), .dataN(mDataN),
    .doneValid(doneValid), .doneTimeout(doneTimeout), .doneData(doneData));

  hs_slave #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MEM_AW(MEM_AW), .LAT_W(LAT_W)) uSlv (
    .clk(sClk), .rstN(sRstN), .msynSeen(!msynSyncN), .busAddrN(busAddrN),
    .busCtlN(busCtlN), .busDataN(busDataN), .slvDelay(slvDelay),
    .ssynN(busSsynN), .dataN(sDataN));
endmodule

// File: tb/hs_link_test.sv
module hs_link_test;
  localparam int CLK_PERIOD = 10;
  localparam int S_PERIOD   = 14;

  typedef struct packed {
    logic        isRead;
    logic        expTo;
    logic [15:0] data;
  } exp_t;

  logic        mClk = 1'b0, sClk = 1'b0, rstN = 1'b0;
  logic [7:0]  cfgSettle = '0;
  logic [15:0] cfgTimeout = 16'd60;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [17:0] reqAddr = '0;
  logic [15:0] reqData = '0;
  logic [7:0]  slvDelay = '0;
  logic        reqReady, doneValid, doneTimeout;
  logic [15:0] doneData;
  logic        busMsynN, busSsynN;
  logic [17:0] busAddrN;
  logic [1:0]  busCtlN;

  int   nChecks = 0, nFails = 0, orderErr = 0;
  logic allowTo = 1'b0;
  exp_t expQ[$];
  logic [15:0] model [64];

  always #(CLK_PERIOD/2) mClk = ~mClk;
  always #(S_PERIOD/2)   sClk = ~sClk;

  hs_link uut (
    .mClk(mClk), .mRstN(rstN), .sClk(sClk), .sRstN(rstN),
    .cfgSettle(cfgSettle), .cfgTimeout(cfgTimeout), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqData(reqData), .reqReady(reqReady),
    .doneValid(doneValid), .doneTimeout(doneTimeout), .doneData(doneData),
    .slvDelay(slvDelay), .busMsynN(busMsynN), .busSsynN(busSsynN),
    .busAddrN(busAddrN), .busCtlN(busCtlN));

  task automatic check(input logic ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R3 ordering monitor on the bus strobes
  always @(negedge busSsynN) if (rstN && busMsynN) orderErr++;
  always @(posedge busMsynN) if (rstN && busSsynN && !allowTo) orderErr++;
  always @(posedge busSsynN) if (rstN && !busMsynN) orderErr++;
  always @(negedge busMsynN) if (rstN && !busSsynN) orderErr++;

  // Scoreboard monitor
  always @(negedge mClk) begin
    if (rstN && doneValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R4 unexpected completion", 1, 0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        check(doneTimeout == e.expTo, e.expTo ? "R8 timeout flag" : "R7 no timeout",
              int'(doneTimeout), int'(e.expTo));
        if (e.isRead && !e.expTo)
          check(doneData == e.data, "R4/R5/R6 read data", int'(doneData), int'(e.data));
      end
    end
  end

  task automatic doXfer(input logic wr, input logic [17:0] a, input logic [15:0] d,
                        input int settle, input int dly, input logic expTo);
    exp_t e;
    int n;
    @(negedge mClk);
    while (!reqReady) @(negedge mClk);
    e.isRead = !wr;
    e.expTo  = expTo;
    e.data   = model[a[5:0]];
    if (wr && !expTo) model[a[5:0]] = d;
    expQ.push_back(e);
    cfgSettle = 8'(settle);
    slvDelay  = 8'(dly);
    allowTo   = expTo;
    reqWrite  = wr;
    reqAddr   = a;
    reqData   = d;
    reqValid  = 1'b1;
    @(posedge mClk);
    @(negedge mClk);
    reqValid = 1'b0;
    check(!reqReady, "R10 busy after accept", int'(reqReady), 0);
    n = 0;
    while (busMsynN && n < 300) begin
      @(posedge mClk);
      n++;
      @(negedge mClk);
    end
    check(n == settle + 1, "R2 settle delay", n, settle + 1);
    check(busAddrN == ~a, "R2 address lines", int'(busAddrN), int'(~a));
    check(busCtlN == (wr ? 2'b01 : 2'b11), "R2 code lines", int'(busCtlN),
          int'(wr ? 2'b01 : 2'b11));
    while (expQ.size() != 0) @(negedge mClk);
    repeat (10) @(negedge mClk);
    allowTo = 1'b0;
  endtask

  logic timedOut = 1'b0;

  initial begin
    #(CLK_PERIOD * 100000);
    timedOut = 1'b1;
    check(1'b0, "watchdog", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge mClk);
    // R1 reset state
    check(reqReady == 1'b1, "R1 reqReady", int'(reqReady), 1);
    check(busMsynN == 1'b1, "R1 request strobe", int'(busMsynN), 1);
    check(busSsynN == 1'b1, "R1 ack strobe", int'(busSsynN), 1);
    check(doneValid == 1'b0, "R1 doneValid", int'(doneValid), 0);
    rstN = 1'b1;
    repeat (5) @(negedge mClk);

    // R5 then R4: basic write and read back
    doXfer(1'b1, 18'h00005, 16'h1234, 2, 0, 1'b0);
    doXfer(1'b0, 18'h00005, 16'h0000, 2, 0, 1'b0);

    // R7: varied settle and latency over several locations
    for (int i = 0; i < 8; i++)
      doXfer(1'b1, 18'(i * 7 + 1), 16'(16'hA000 + i * 16'h0111), i % 6, (i * 5) % 12, 1'b0);
    for (int i = 7; i >= 0; i--)
      doXfer(1'b0, 18'(i * 7 + 1), 16'h0, (i + 3) % 6, (i * 3 + 2) % 12, 1'b0);

    // R6: aliasing above the low six address bits
    doXfer(1'b1, 18'h2_0007, 16'h5A5A, 1, 3, 1'b0);
    doXfer(1'b0, 18'h0_0007, 16'h0, 0, 11, 1'b0);
    doXfer(1'b0, 18'h1_FFC7, 16'h0, 4, 0, 1'b0);

    // R8: watchdog on read and on write; R9: aborted write leaves memory unchanged
    doXfer(1'b1, 18'h00009, 16'h0F0F, 1, 1, 1'b0);
    cfgTimeout = 16'd20;
    doXfer(1'b0, 18'h00009, 16'h0, 1, 200, 1'b1);
    doXfer(1'b1, 18'h00009, 16'hDEAD, 1, 200, 1'b1);
    cfgTimeout = 16'd60;
    repeat (40) @(negedge mClk);
    doXfer(1'b0, 18'h00009, 16'h0, 1, 2, 1'b0);

    check(orderErr == 0, "R3 strobe ordering", orderErr, 0);
    if (!timedOut) begin
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule